// File: doc/BRIEF.md
# Modulo-Scheduled Loop Branch Controller

This block makes the loop-closing branch decision for software-pipelined loops. It holds two down-counters. The iteration counter records how many more kernel passes start new work. The drain counter records how many further passes are needed to empty the pipeline after new work stops. For every loop branch the block reports three things:

- whether the branch is taken;
- the value written into the first stage predicate;
- whether the register file must rotate.

A small shift register of stage predicates models how the first predicate ripples into later stages on each rotation.

Two branch flavours are supported:

- **Counted loops.** The iteration counter decides whether new work starts.
- **Data-terminated loops.** A condition predicate computed in the loop body makes that decision instead, and only the drain counter is consumed.

Software preloads the counters and the stage predicates through load ports before entering the loop. A load takes priority over a branch update in the same cycle.

The branch decision outputs are combinational from the current counter state and the branch inputs. Counter and predicate updates take effect at the next rising clock edge.

Top module: `loop_branch_ctrl`

## Requirements
- R1: A counted branch (`br_kind`=0) with iteration count ITC>0 sets `br_taken`=1, `br_exit`=0, `p16_val`=1 and `rotate`=1 in the same cycle, and ITC is one lower after the next edge while the drain count DRC is unchanged.
- R2: A counted branch with ITC=0 and DRC>1 sets `br_taken`=1, `p16_val`=0 and `rotate`=1, and DRC drops by one at the next edge while ITC stays 0.
- R3: A counted branch with ITC=0 and DRC=1 sets `br_taken`=0, `br_exit`=1, `p16_val`=0 and `rotate`=1, and DRC becomes 0.
- R4: Any branch that does not start new work and finds DRC=0 gives `br_taken`=0, `br_exit`=1, `rotate`=0 and `p16_val`=0, and both counters keep their values, so neither counter ever goes below zero.
- R5: A data-terminated branch (`br_kind`=1) with `cond_pred`=1 sets `br_taken`=1, `p16_val`=1 and `rotate`=1, and leaves both counters unchanged.
- R6: A data-terminated branch with `cond_pred`=0 behaves like a counted branch at ITC=0. It is taken with a DRC decrement when DRC>1, and exits with a DRC decrement when DRC=1. In both cases `p16_val`=0 and `rotate`=1.
- R7: On a branch with `rotate`=1, after the next edge `stage_pred[k]` holds the old `stage_pred[k-1]` and `stage_pred[0]` holds `p16_val`. On a branch with `rotate`=0, only `stage_pred[0]` takes `p16_val`.
- R8: `itc_ld_en`, `drc_ld_en` and `pred_ld_en` load their data at the next edge and override any branch update of the same state in that cycle. The branch outputs in that cycle still follow the pre-load state.
- R9: With `br_valid`=0, `br_taken`, `br_exit`, `p16_we` and `rotate` are 0, and counters and stage predicates hold.
- R10: After reset, ITC, DRC and all stage predicates are 0. Reset is asserted asynchronously and released through a two-flop synchroniser.
- R11: A copy loop preloaded with ITC=n-1, DRC=2 and `stage_pred`=0b0001 executes n+1 passes (n taken branches, then one exit) and finishes with ITC=0 and DRC=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A loop branch executes this cycle |
| br_kind | input | 1 | 0 counted, 1 data-terminated |
| cond_pred | input | 1 | Loop condition for data-terminated branches |
| itc_ld_en | input | 1 | Load iteration counter |
| itc_ld_data | input | LC_W (64) | Iteration counter load value |
| drc_ld_en | input | 1 | Load drain counter |
| drc_ld_data | input | EC_W (6) | Drain counter load value |
| pred_ld_en | input | 1 | Load stage predicates |
| pred_ld_data | input | NSTAGE (4) | Stage predicate load value |
| br_taken | output | 1 | Branch goes back to the loop head |
| br_exit | output | 1 | Branch falls through, loop done |
| p16_we | output | 1 | First stage predicate is written |
| p16_val | output | 1 | Value written to first stage predicate |
| rotate | output | 1 | Rotation strobe to the register renamer |
| itc_q | output | LC_W (64) | Current iteration count |
| drc_q | output | EC_W (6) | Current drain count |
| stage_pred | output | NSTAGE (4) | Stage predicates, bit 0 is the first stage |

## Verification
The bench aims at the boundary between drain counts of 1 and 0. A design that tested DRC>0 instead of DRC>1 would take one pass too many and then rotate on an empty drain. The bench also issues branches while DRC is 0, where a wrapping decrement would turn a finished loop into 63 extra passes. It drives loads in the same cycle as branches, so a wrong priority shows up as a counter that misses its preload by one. Finally, it runs complete counted and data-terminated loops and checks the rippling stage predicates. A shift in the wrong direction, or a shift on a non-rotating branch, corrupts the later stages.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

  typedef enum logic {
    BK_COUNTED = 1'b0,
    BK_WHILE   = 1'b1
  } br_kind_e;

  typedef struct packed {
    logic taken;
    logic fall;
    logic rotate;
    logic first_val;
    logic itc_dec;
    logic drc_dec;
  } br_dec_t;

endpackage

// File: rtl/lbc_rst_sync.sv
module lbc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/lbc_decide.sv
module lbc_decide
  import lbc_pkg::*;
#(
  parameter int LC_W = 64,
  parameter int EC_W = 6
) (
  input  logic            valid,
  input  br_kind_e        kind,
  input  logic            cond,
  input  logic [LC_W-1:0] itc,
  input  logic [EC_W-1:0] drc,
  output br_dec_t         dec
);

  localparam logic [EC_W-1:0] DRC_ONE = EC_W'(1);

  logic itc_nz;
  logic drc_nz;
  logic drc_gt1;
  logic new_work;

  assign itc_nz  = |itc;
  assign drc_nz  = |drc;
  assign drc_gt1 = drc > DRC_ONE;

  // New work starts when the iteration count or the condition allows it.
  always_comb begin
    new_work = 1'b0;
    if (valid) begin
      if (kind == BK_COUNTED) new_work = itc_nz;
      else                    new_work = cond;
    end
  end

  always_comb begin
    dec = '0;
    if (valid) begin
      dec.first_val = new_work;
      if (new_work) begin
        dec.taken   = 1'b1;
        dec.rotate  = 1'b1;
        dec.itc_dec = (kind == BK_COUNTED);
      end else if (drc_nz) begin
        dec.rotate  = 1'b1;
        dec.drc_dec = 1'b1;
        dec.taken   = drc_gt1;
        dec.fall    = !drc_gt1;
      end else begin
        dec.fall    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/lbc_down_reg.sv
module lbc_down_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [W-1:0] ld_data,
  input  logic         dec_en,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nx;
  logic         q_en;

  // A load wins over a decrement; a zero value never decrements.
  always_comb begin
    q_en = 1'b0;
    q_nx = q;
    if (ld_en) begin
      q_en = 1'b1;
      q_nx = ld_data;
    end else if (dec_en && (|q)) begin
      q_en = 1'b1;
      q_nx = q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nx;
  end

endmodule

// File: rtl/lbc_stage_preds.sv
module lbc_stage_preds #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [N-1:0] ld_data,
  input  logic         wr_en,
  input  logic         wr_val,
  input  logic         shift,
  output logic [N-1:0] q
);

  logic [N-1:0] q_nx;
  logic         q_en;
  logic [N-1:0] shifted;

  assign shifted[0] = wr_val;

  genvar k;
  generate
    for (k = 1; k < N; k++) begin : g_ripple
      assign shifted[k] = q[k-1];
    end
  endgenerate

  always_comb begin
    q_en = ld_en | wr_en;
    q_nx = q;
    if (ld_en)      q_nx = ld_data;
    else if (shift) q_nx = shifted;
    else if (wr_en) q_nx[0] = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_nx;
  end

endmodule

// File: rtl/loop_branch_ctrl.sv
module loop_branch_ctrl
  import lbc_pkg::*;
#(
  parameter int LC_W   = 64,
  parameter int EC_W   = 6,
  parameter int NSTAGE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic              br_kind,
  input  logic              cond_pred,
  input  logic              itc_ld_en,
  input  logic [LC_W-1:0]   itc_ld_data,
  input  logic              drc_ld_en,
  input  logic [EC_W-1:0]   drc_ld_data,
  input  logic              pred_ld_en,
  input  logic [NSTAGE-1:0] pred_ld_data,
  output logic              br_taken,
  output logic              br_exit,
  output logic              p16_we,
  output logic              p16_val,
  output logic              rotate,
  output logic [LC_W-1:0]   itc_q,
  output logic [EC_W-1:0]   drc_q,
  output logic [NSTAGE-1:0] stage_pred
);

  logic     rst_int_n;
  br_dec_t  dec;
  br_kind_e kind;

  assign kind = br_kind_e'(br_kind);

  lbc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  lbc_decide #(.LC_W(LC_W), .EC_W(EC_W)) u_dec (
    .valid (br_valid),
    .kind  (kind),
    .cond  (cond_pred),
    .itc   (itc_q),
    .drc   (drc_q),
    .dec   (dec)
  );

  lbc_down_reg #(.W(LC_W)) u_itc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ld_en   (itc_ld_en),
    .ld_data (itc_ld_data),
    .dec_en  (dec.itc_dec),
    .q       (itc_q)
  );

  lbc_down_reg #(.W(EC_W)) u_drc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ld_en   (drc_ld_en),
    .ld_data (drc_ld_data),
    .dec_en  (dec.drc_dec),
    .q       (drc_q)
  );

  lbc_stage_preds #(.N(NSTAGE)) u_preds (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ld_en   (pred_ld_en),
    .ld_data (pred_ld_data),
    .wr_en   (br_valid),
    .wr_val  (dec.first_val),
    .shift   (dec.rotate),
    .q       (stage_pred)
  );

  assign br_taken = dec.taken;
  assign br_exit  = dec.fall;
  assign p16_we   = br_valid;
  assign p16_val  = dec.first_val;
  assign rotate   = dec.rotate;

endmodule

// File: rtl/lbc_checker.sv
module lbc_checker #(
  parameter int LC_W   = 64,
  parameter int EC_W   = 6,
  parameter int NSTAGE = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              br_valid,
  input logic              br_kind,
  input logic              cond_pred,
  input logic              itc_ld_en,
  input logic [LC_W-1:0]   itc_ld_data,
  input logic              drc_ld_en,
  input logic [EC_W-1:0]   drc_ld_data,
  input logic              pred_ld_en,
  input logic              br_taken,
  input logic              br_exit,
  input logic              p16_val,
  input logic              rotate,
  input logic [LC_W-1:0]   itc_q,
  input logic [EC_W-1:0]   drc_q,
  input logic [NSTAGE-1:0] stage_pred
);

  p_count_taken_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !br_kind && itc_q != '0) |-> (br_taken && p16_val && rotate));

  p_count_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !br_kind && itc_q != '0 && !itc_ld_en) |=> (itc_q == $past(itc_q) - LC_W'(1)));

  p_drain_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !br_kind && itc_q == '0 && drc_q == EC_W'(1)) |-> (br_exit && !br_taken && rotate));

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drc_q == '0 && !drc_ld_en) |=> (drc_q == '0));

  p_while_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_kind && cond_pred && !drc_ld_en) |=> $stable(drc_q));

  p_ripple_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate && !pred_ld_en) |=> (stage_pred[1] == $past(stage_pred[0])));

  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    itc_ld_en |=> (itc_q == $past(itc_ld_data)));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |-> (!br_taken && !br_exit && !rotate));

  p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |-> (br_taken != br_exit));

endmodule

bind loop_branch_ctrl lbc_checker #(
  .LC_W(LC_W), .EC_W(EC_W), .NSTAGE(NSTAGE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_kind(br_kind),
  .cond_pred(cond_pred), .itc_ld_en(itc_ld_en), .itc_ld_data(itc_ld_data),
  .drc_ld_en(drc_ld_en), .drc_ld_data(drc_ld_data), .pred_ld_en(pred_ld_en),
  .br_taken(br_taken), .br_exit(br_exit), .p16_val(p16_val), .rotate(rotate),
  .itc_q(itc_q), .drc_q(drc_q), .stage_pred(stage_pred)
);

// File: tb/loop_branch_ctrl_test.sv
`timescale 1ns/1ps
module loop_branch_ctrl_test;

  localparam int LC_W = 64;
  localparam int EC_W = 6;
  localparam int NS   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic br_valid = 1'b0, br_kind = 1'b0, cond_pred = 1'b0;
  logic itc_ld_en = 1'b0, drc_ld_en = 1'b0, pred_ld_en = 1'b0;
  logic [LC_W-1:0] itc_ld_data = '0;
  logic [EC_W-1:0] drc_ld_data = '0;
  logic [NS-1:0]   pred_ld_data = '0;
  logic br_taken, br_exit, p16_we, p16_val, rotate;
  logic [LC_W-1:0] itc_q;
  logic [EC_W-1:0] drc_q;
  logic [NS-1:0]   stage_pred;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // reference state
  logic [LC_W-1:0] m_itc = '0;
  int              m_drc = 0;
  logic [NS-1:0]   m_pr  = '0;
  string           m_stag = "R10";

  always #2 clk = ~clk;

  loop_branch_ctrl #(.LC_W(LC_W), .EC_W(EC_W), .NSTAGE(NS)) uut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_kind(br_kind),
    .cond_pred(cond_pred), .itc_ld_en(itc_ld_en), .itc_ld_data(itc_ld_data),
    .drc_ld_en(drc_ld_en), .drc_ld_data(drc_ld_data), .pred_ld_en(pred_ld_en),
    .pred_ld_data(pred_ld_data), .br_taken(br_taken), .br_exit(br_exit),
    .p16_we(p16_we), .p16_val(p16_val), .rotate(rotate), .itc_q(itc_q),
    .drc_q(drc_q), .stage_pred(stage_pred)
  );

  task automatic check(string tag, string what, logic [LC_W-1:0] act, logic [LC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Reference decision for the current inputs and state.
  function automatic logic [4:0] model_out(output string tag);
    logic run, tk, ex, rot, pv;
    run = br_kind ? cond_pred : (m_itc != '0);
    tk = 0; ex = 0; rot = 0; pv = 0;
    if (!br_valid) tag = "R9";
    else begin
      pv = run;
      if (run) begin tk = 1; rot = 1; tag = br_kind ? "R5" : "R1"; end
      else if (m_drc > 1) begin tk = 1; rot = 1; tag = br_kind ? "R6" : "R2"; end
      else if (m_drc == 1) begin ex = 1; rot = 1; tag = br_kind ? "R6" : "R3"; end
      else begin ex = 1; tag = "R4"; end
    end
    return {tk, ex, br_valid, pv, rot};
  endfunction

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    string tag;
    logic [4:0] e;
    if (rst_n && !done) begin
      e = model_out(tag);
      check(tag, "br_taken", LC_W'(br_taken), LC_W'(e[4]));
      check(tag, "br_exit",  LC_W'(br_exit),  LC_W'(e[3]));
      check(tag, "p16_we",   LC_W'(p16_we),   LC_W'(e[2]));
      check(tag, "p16_val",  LC_W'(p16_val),  LC_W'(e[1]));
      check(tag, "rotate",   LC_W'(rotate),   LC_W'(e[0]));
      check(m_stag, "itc_q", itc_q, m_itc);
      check(m_stag, "drc_q", LC_W'(drc_q), LC_W'(m_drc));
      check((m_stag == "R8") ? "R8" : "R7", "stage_pred", LC_W'(stage_pred), LC_W'(m_pr));
    end
  end

  // Reference state update at the edge.
  always @(posedge clk) begin
    string tag;
    logic [4:0] e;
    logic run;
    if (!rst_n) begin
      m_itc = '0; m_drc = 0; m_pr = '0; m_stag = "R10";
    end else begin
      e = model_out(tag);
      m_stag = tag;
      run = br_kind ? cond_pred : (m_itc != '0);
      if (br_valid) begin
        if (run) begin if (!br_kind) m_itc = m_itc - 1; end
        else if (m_drc > 0) m_drc = m_drc - 1;
        if (e[0]) m_pr = {m_pr[NS-2:0], run};
        else      m_pr[0] = run;
      end
      if (itc_ld_en)  begin m_itc = itc_ld_data; m_stag = "R8"; end
      if (drc_ld_en)  begin m_drc = int'(drc_ld_data); m_stag = "R8"; end
      if (pred_ld_en) begin m_pr = pred_ld_data; m_stag = "R8"; end
    end
  end

  task automatic idle();
    @(posedge clk); #1;
    br_valid = 0; itc_ld_en = 0; drc_ld_en = 0; pred_ld_en = 0;
  endtask

  task automatic preload(logic [LC_W-1:0] it, int dr, logic [NS-1:0] pr);
    @(posedge clk); #1;
    br_valid = 0;
    itc_ld_en = 1; itc_ld_data = it;
    drc_ld_en = 1; drc_ld_data = EC_W'(dr);
    pred_ld_en = 1; pred_ld_data = pr;
  endtask

  task automatic branch(logic kind, logic cnd, output logic tk, output logic ex);
    @(posedge clk); #1;
    itc_ld_en = 0; drc_ld_en = 0; pred_ld_en = 0;
    br_valid = 1; br_kind = kind; cond_pred = cnd;
    @(negedge clk);
    tk = br_taken; ex = br_exit;
  endtask

  initial begin
    logic tk, ex;
    int passes;
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R10", "itc after reset", itc_q, '0);
    check("R10", "drc after reset", LC_W'(drc_q), '0);
    check("R10", "preds after reset", LC_W'(stage_pred), '0);

    // R11 copy loop with n = 5
    preload(4, 2, 4'b0001);
    passes = 0;
    do begin branch(0, 0, tk, ex); passes++; end while (!ex && passes < 20);
    idle();
    @(negedge clk);
    check("R11", "copy loop passes", LC_W'(passes), 6);
    check("R11", "itc at exit", itc_q, '0);
    check("R11", "drc at exit", LC_W'(drc_q), '0);

    // R4 branches with both counters empty, both kinds
    branch(0, 1, tk, ex);
    branch(1, 0, tk, ex);
    idle();

    // R5 and R6 data-terminated loop
    preload('0, 3, 4'b0001);
    repeat (4) branch(1, 1, tk, ex);
    passes = 0;
    do begin branch(1, 0, tk, ex); passes++; end while (!ex && passes < 20);
    idle();
    @(negedge clk);
    check("R6", "while drain passes", LC_W'(passes), 3);

    // R8 load in the same cycle as a branch
    preload(10, 5, 4'b1010);
    @(posedge clk); #1;
    pred_ld_en = 0;
    br_valid = 1; br_kind = 0;
    itc_ld_en = 1; itc_ld_data = 64'd77;
    drc_ld_en = 1; drc_ld_data = 6'd9;
    idle();
    @(negedge clk);
    check("R8", "itc load over branch", itc_q, 64'd77);
    check("R8", "drc load over branch", LC_W'(drc_q), 64'd9);

    // R1 large count
    preload({LC_W{1'b1}}, 63, 4'b0000);
    repeat (3) branch(0, 0, tk, ex);
    idle();

    // mixed pseudo-random traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      @(posedge clk); #1;
      br_valid    = lfsr[0] | lfsr[1];
      br_kind     = lfsr[2];
      cond_pred   = lfsr[3] & lfsr[4];
      itc_ld_en   = (lfsr[7:5] == 3'b000);
      itc_ld_data = LC_W'(lfsr[9:8]);
      drc_ld_en   = (lfsr[12:10] == 3'b000);
      drc_ld_data = EC_W'(lfsr[14:13]);
      pred_ld_en  = (lfsr[15:13] == 3'b111);
      pred_ld_data = lfsr[3:0];
    end
    idle();
    repeat (2) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule